// File: doc/BRIEF.md
# Raster Timing Generator with Vertical-Blank Status

This block keeps the beam position for one video frame. A dot counter advances on every dot clock and a scanline counter steps each time the dot counter wraps. From that position the block derives a vertical-blank flag, a horizontal-blank indication, a one-cycle frame-done strobe, a gated interrupt request toward the CPU and a running 32-bit frame count.

The CPU controls a single interrupt-enable register through a write strobe. It can sample two status bytes through a combinational read port. The frame-done strobe marks the point where a renderer would hand over a completed picture. Pixel generation and output are outside this block.

Top module: `raster_timing`

## Requirements
- R1: While reset is asserted, dot, line, frame count, vblank, interrupt enable, nmi_req and frame_done are all 0.
- R2: The dot counter runs 0,1,...,340 and returns to 0 after 340, so a line is 341 dots long. The line counter increments on that wrap and holds at all other times.
- R3: When the line counter becomes 225, vblank becomes 1 and frame_done is high for exactly that one cycle.
- R4: When line 259 wraps, the line counter returns to 0, vblank becomes 0 and the frame count increments by one, rolling over modulo 2^32.
- R5: nmi_req is a one-cycle pulse, raised only in the first cycle of line 225, and only if the interrupt enable was 1 before that edge.
- R6: A cycle with wr_en high loads bit 7 of wr_data into the interrupt enable, and bits 6..0 are ignored. Setting the enable while vblank is already high raises no request in that frame.
- R7: With rd_sel = 0, rd_data is 0x80 while vblank is 1 and 0x00 otherwise.
- R8: With rd_sel = 1, rd_data bit 7 is 1 when line >= 225, and bit 6 is 1 when dot >= 0x121 or dot <= 0x15. Both bits can be 1 together, and bits 5..0 are 0.
- R9: hblank is 1 exactly when dot >= 0x121 or dot <= 0x15.
- R10: If an enable write falls on the last dot of line 224, the enable value held before that edge decides the request. The written value takes effect only afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the interrupt-enable register |
| wr_data | input | 8 | Write data; bit 7 is the enable |
| rd_sel | input | 1 | Status select: 0 interrupt byte, 1 timing byte |
| rd_data | output | 8 | Selected status byte |
| dot | output | 9 | Current dot within the line |
| line | output | 9 | Current scanline |
| vblank | output | 1 | Vertical-blank flag |
| hblank | output | 1 | Horizontal-blank window |
| nmi_req | output | 1 | One-cycle interrupt request |
| frame_done | output | 1 | One-cycle strobe at vblank entry |
| frame_cnt | output | 32 | Completed-frame count |

## Verification
The CPU write of the interrupt enable and the entry into line 225 can fall in the same cycle. The bench forces this collision by issuing a directed write on the last dot of line 224 in both frames it runs. In the first frame the enable is already 1 and the write clears it. In the second frame the enable is 0 and the write sets it. A pulse is expected only in the first frame, and no pulse at all may appear later in either vblank. The bench also compares every status read against its own position model, including the cycles where the wrapped hblank window and the vblank line overlap.

// File: rtl/rt_pkg.sv
package rt_pkg;
  typedef enum logic {SEL_IRQ = 1'b0, SEL_TIMING = 1'b1} stat_sel_e;

  // Horizontal-blank window that wraps past the end of the line.
  function automatic logic hb_window(input int unsigned d, input int unsigned s,
                                     input int unsigned e);
    return (d >= s) || (d <= e);
  endfunction

  function automatic logic [7:0] irq_byte(input logic vbl);
    return {vbl, 7'b0};
  endfunction

  function automatic logic [7:0] timing_byte(input logic in_vbl, input logic hb);
    return {in_vbl, hb, 6'b0};
  endfunction
endpackage

// File: rtl/rt_dot_ctr.sv
module rt_dot_ctr #(
  parameter int DOT_LAST = 340,
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [DW-1:0] dot,
  output logic          wrap
);
  localparam logic [DW-1:0] LAST_D = DW'(DOT_LAST);

  assign wrap = (dot == LAST_D);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dot <= '0;
    else if (wrap) dot <= '0;
    else           dot <= dot + 1'b1;
  end
endmodule

// File: rtl/rt_line_ctr.sv
module rt_line_ctr #(
  parameter int VBL_LINE  = 225,
  parameter int WRAP_LINE = 260,
  parameter int LW = 9,
  parameter int FW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [LW-1:0] line,
  output logic          vblank,
  output logic          enter_vbl,
  output logic          frame_wrap,
  output logic [FW-1:0] frame_cnt
);
  localparam logic [LW-1:0] VBL_L  = LW'(VBL_LINE);
  localparam logic [LW-1:0] WRAP_L = LW'(WRAP_LINE);

  logic [LW-1:0] line_inc;

  always_comb begin
    line_inc   = line + 1'b1;
    enter_vbl  = adv && (line_inc == VBL_L);
    frame_wrap = adv && (line_inc == WRAP_L);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line      <= '0;
      vblank    <= 1'b0;
      frame_cnt <= '0;
    end else if (adv) begin
      line <= frame_wrap ? '0 : line_inc;
      if (enter_vbl)       vblank <= 1'b1;
      else if (frame_wrap) vblank <= 1'b0;
      if (frame_wrap)      frame_cnt <= frame_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rt_status_mux.sv
module rt_status_mux (
  input  logic       sel,
  input  logic       vblank,
  input  logic       in_vbl_lines,
  input  logic       hblank,
  output logic [7:0] rd_data
);
  import rt_pkg::*;

  always_comb begin
    if (sel == SEL_TIMING) rd_data = timing_byte(in_vbl_lines, hblank);
    else                   rd_data = irq_byte(vblank);
  end
endmodule

// File: rtl/raster_timing.sv
module raster_timing #(
  parameter int DOT_LAST  = 340,
  parameter int VBL_LINE  = 225,
  parameter int WRAP_LINE = 260,
  parameter int HB_START  = 'h121,
  parameter int HB_END    = 'h15,
  parameter int FW        = 32,
  localparam int DW = $clog2(DOT_LAST + 1),
  localparam int LW = $clog2(WRAP_LINE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  input  logic          rd_sel,
  output logic [7:0]    rd_data,
  output logic [DW-1:0] dot,
  output logic [LW-1:0] line,
  output logic          vblank,
  output logic          hblank,
  output logic          nmi_req,
  output logic          frame_done,
  output logic [FW-1:0] frame_cnt
);
  import rt_pkg::*;

  localparam logic [LW-1:0] VBL_L = LW'(VBL_LINE);

  // Named internal events, visible to the bound checker.
  logic dot_wrap;
  logic enter_vbl;
  logic frame_wrap;
  logic nmi_en;
  logic in_vbl_lines;

  rt_dot_ctr #(.DOT_LAST(DOT_LAST), .DW(DW)) u_dot (
    .clk(clk), .rst_n(rst_n), .dot(dot), .wrap(dot_wrap)
  );

  rt_line_ctr #(.VBL_LINE(VBL_LINE), .WRAP_LINE(WRAP_LINE), .LW(LW), .FW(FW)) u_line (
    .clk(clk), .rst_n(rst_n), .adv(dot_wrap), .line(line), .vblank(vblank),
    .enter_vbl(enter_vbl), .frame_wrap(frame_wrap), .frame_cnt(frame_cnt)
  );

  assign hblank       = hb_window(32'(dot), HB_START, HB_END);
  assign in_vbl_lines = (line >= VBL_L);

  rt_status_mux u_stat (
    .sel(rd_sel), .vblank(vblank), .in_vbl_lines(in_vbl_lines),
    .hblank(hblank), .rd_data(rd_data)
  );

  // The request samples the enable as it stood before this edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_en     <= 1'b0;
      nmi_req    <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      if (wr_en) nmi_en <= wr_data[7];
      nmi_req    <= enter_vbl & nmi_en;
      frame_done <= enter_vbl;
    end
  end
endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk #(
  parameter int DOT_LAST  = 340,
  parameter int WRAP_LINE = 260,
  parameter int DW = 9,
  parameter int LW = 9,
  parameter int FW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] dot,
  input logic [LW-1:0] line,
  input logic          vblank,
  input logic          nmi_req,
  input logic          frame_done,
  input logic          nmi_en,
  input logic [FW-1:0] frame_cnt
);
  localparam logic [DW-1:0] LAST_D = DW'(DOT_LAST);
  localparam logic [LW-1:0] LASTL  = LW'(WRAP_LINE - 1);

  a_r2_dot_step: assert property (@(posedge clk) disable iff (!rst_n)
    (dot != LAST_D) |=> (dot == $past(dot) + 1'b1));
  a_r2_dot_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (dot == LAST_D) |=> (dot == '0));
  a_r3_fd_on_vbl_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vblank) |-> frame_done);
  a_r3_fd_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
  a_r4_frame_step: assert property (@(posedge clk) disable iff (!rst_n)
    (line == LASTL && dot == LAST_D) |=> (frame_cnt == $past(frame_cnt) + 1'b1));
  a_r5_nmi_at_entry: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |-> frame_done);
  a_r5_nmi_gated: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |-> $past(nmi_en));
endmodule

bind raster_timing raster_timing_chk #(
  .DOT_LAST(DOT_LAST), .WRAP_LINE(WRAP_LINE), .DW(DW), .LW(LW), .FW(FW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dot(dot), .line(line), .vblank(vblank),
  .nmi_req(nmi_req), .frame_done(frame_done), .nmi_en(nmi_en), .frame_cnt(frame_cnt)
);

// File: tb/sim_raster_timing.sv
`timescale 1ns/1ps
module sim_raster_timing;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic        rd_sel = 1'b0;
  logic [7:0]  rd_data;
  logic [8:0]  dot;
  logic [8:0]  line;
  logic        vblank, hblank, nmi_req, frame_done;
  logic [31:0] frame_cnt;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  raster_timing u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .dot(dot), .line(line), .vblank(vblank), .hblank(hblank),
    .nmi_req(nmi_req), .frame_done(frame_done), .frame_cnt(frame_cnt)
  );

  always #2 clk = ~clk;

  // Bench model of the position and flags.
  int m_dot = 0, m_line = 0;
  int unsigned m_frame = 0;
  bit m_vbl = 0, m_en = 0, m_nmi = 0, m_fd = 0;
  int nmi_seen = 0;

  function automatic bit exp_hb(int d);
    return (d > 288) || (d < 22);
  endfunction

  function automatic logic [7:0] exp_stat(bit sel, int l, int d, bit vbl);
    if (!sel) return vbl ? 8'h80 : 8'h00;
    return (l >= 225 ? 8'h80 : 8'h00) | (exp_hb(d) ? 8'h40 : 8'h00);
  endfunction

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (line %0d dot %0d)", req, act, exp, m_line, m_dot);
    end
  endtask

  task automatic model_step(bit we, logic [7:0] wd);
    m_nmi = 0; m_fd = 0;
    if (m_dot == 340) begin
      m_dot = 0;
      if (m_line + 1 == 225) begin
        m_line = 225; m_vbl = 1; m_fd = 1; m_nmi = m_en;
      end else if (m_line + 1 == 260) begin
        m_line = 0; m_vbl = 0; m_frame++;
      end else m_line++;
    end else m_dot++;
    if (we) m_en = wd[7];
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h5eed_2a17));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 dot", dot, 0);
    chk("R1 line", line, 0);
    chk("R1 frame", frame_cnt, 0);
    chk("R1 vblank", vblank, 0);
    chk("R1 nmi", nmi_req, 0);
    chk("R1 fd", frame_done, 0);
    rst_n = 1'b1;
    @(posedge clk); #0.5; model_step(0, 8'h00);

    for (int cyc = 0; cyc < 2 * 341 * 260 + 40; cyc++) begin
      bit want, we, sel;
      logic [7:0] wd;
      @(negedge clk);
      chk("R2 dot", dot, m_dot);
      chk("R2 line", line, m_line);
      chk("R3 vblank", vblank, m_vbl);
      chk("R3 frame_done", frame_done, m_fd);
      chk("R4 frame_cnt", frame_cnt, m_frame);
      chk("R5 nmi_req", nmi_req, m_nmi);
      chk("R9 hblank", hblank, exp_hb(m_dot));
      if (nmi_req) nmi_seen++;

      want = m_vbl ? 1'b1 : (m_frame == 0);
      wd = 8'($urandom);
      if (m_dot == 340 && m_line == 224) begin
        // R10: collision of enable write with vblank entry, opposite polarity
        we = 1; wd[7] = ~m_en;
      end else begin
        // R6: random low bits must not matter; late enable inside vblank
        we = ($urandom % 32) == 0; wd[7] = want;
      end
      sel = 1'($urandom);
      wr_en = we; wr_data = wd; rd_sel = sel;
      #0.5;
      if (sel) chk("R8 status timing", rd_data, exp_stat(1, m_line, m_dot, m_vbl));
      else     chk("R7 status irq", rd_data, exp_stat(0, m_line, m_dot, m_vbl));
      @(posedge clk); #0.5;
      model_step(we, wd);
      if (fails >= 50) break;
    end
    @(negedge clk);
    wr_en = 0;
    // R5 / R10: exactly one request over two frames (first frame only)
    chk("R10 total nmi pulses", nmi_seen, 1);
    chk("R4 frames completed", frame_cnt, 2);
    done = 1;
    finish_run();
  end
endmodule